// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block takes one decoded request descriptor at a time and walks it through a fixed series of phases. First comes an optional semaphore gate before the transfer. Then it issues the transfer command, either bulk or linked-list, and waits for the engine to report that it is done. After that comes an optional semaphore gate after the transfer, then an optional doorbell write. Last, it can emit a completion entry. Any phase the descriptor does not enable is skipped and costs no cycle.

The descriptor is checked at the moment it is accepted. Three faults stop it: an illegal transfer type, a reserved doorbell width, or a doorbell address that does not match the selected width. A faulty descriptor runs none of the phases. It goes straight to the completion entry, if one was asked for, and that entry carries a code naming the fault. The doorbell write is placed on the byte lanes picked by the low address bits. Each lane it uses has its strobe set, and the other lanes are zero.

Top module: `dma_req_seq`

## Requirements
- R1: After reset `req_ready` is 1 and every phase output is 0. A descriptor is taken on a cycle where `req_valid` and `req_ready` are both high. While a descriptor is being worked, `req_ready` stays low and no phase output is high in a cycle where `req_ready` is high.
- R2: An accepted descriptor's outputs appear in this order: pre-gate, transfer command, post-gate, doorbell, completion. At most one of them is active in any cycle.
- R3: When `req_pre_en` is 1, `sem_pre_req` stays high until `sem_pre_ok` is seen. While it waits, no transfer, doorbell or completion is presented. When `req_pre_en` is 0, the phase is skipped.
- R4: `req_type` 1 (to device) or 2 (from device) issues one command carrying `xfer_dir` = type, `xfer_bulk` (1 bulk, 0 linked list), source, destination and the 32-bit length. The command holds until `xfer_ready`, and the block then waits for `xfer_done`. Type 0 issues no command.
- R5: When `req_post_en` is 1, `sem_post_req` stays high until `sem_post_ok`, and no doorbell or completion is presented before that. When `req_post_en` is 0, the phase is skipped.
- R6: When `req_db_en` is 1, one doorbell write is emitted. `req_db_width` selects 0 = 4 bytes, 1 = 2 bytes, 2 = 1 byte. The data is masked to that width and shifted left by 8 × address bits [1:0]. `db_strb` covers exactly those byte lanes, and the write holds until `db_ready`.
- R7: When `req_want_rsp` is 1, one completion is emitted carrying `req_id` and the force-interrupt flag. A successful descriptor gets code 0. The completion holds until `rsp_ready`.
- R8: Fault codes are 1 for transfer type 3, 2 for doorbell width 3 with the doorbell enabled, and 3 for a misaligned enabled doorbell (a 4-byte write needs address bits [1:0] = 0, a 2-byte write needs bit 0 = 0). When more than one fault is present, the lowest code wins. A faulty descriptor runs no transfer, gate or doorbell.
- R9: When `req_want_rsp` is 0, no completion is emitted, even for a faulty descriptor. A disabled doorbell's width and address raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Sequencer idle, can take a descriptor |
| req_id | input | ID_W | Request identifier |
| req_force_irq | input | 1 | Force interrupt on completion |
| req_want_rsp | input | 1 | Emit a completion entry |
| req_bulk | input | 1 | 1 bulk, 0 linked list |
| req_type | input | 2 | 0 none, 1 to device, 2 from device, 3 illegal |
| req_src | input | ADDR_W | Source or list address |
| req_dst | input | ADDR_W | Destination address |
| req_len | input | LEN_W | Transfer length |
| req_pre_en | input | 1 | Pre-transfer gate enabled |
| req_post_en | input | 1 | Post-transfer gate enabled |
| req_db_en | input | 1 | Doorbell write enabled |
| req_db_width | input | 2 | 0 four bytes, 1 two, 2 one, 3 reserved |
| req_db_addr | input | ADDR_W | Doorbell address |
| req_db_data | input | 32 | Doorbell data |
| sem_pre_req | output | 1 | Pre-gate query active |
| sem_pre_ok | input | 1 | Pre-gate condition true |
| xfer_valid | output | 1 | Transfer command valid |
| xfer_ready | input | 1 | Engine accepts command |
| xfer_bulk | output | 1 | Bulk / linked-list select |
| xfer_dir | output | 2 | Direction code |
| xfer_src | output | ADDR_W | Source address |
| xfer_dst | output | ADDR_W | Destination address |
| xfer_len | output | LEN_W | Length |
| xfer_done | input | 1 | Engine finished |
| sem_post_req | output | 1 | Post-gate query active |
| sem_post_ok | input | 1 | Post-gate conditions true |
| db_valid | output | 1 | Doorbell write valid |
| db_ready | input | 1 | Write port accepts |
| db_addr | output | ADDR_W | Doorbell address |
| db_data | output | 32 | Lane-aligned doorbell data |
| db_strb | output | 4 | Byte-lane strobes |
| rsp_valid | output | 1 | Completion valid |
| rsp_ready | input | 1 | Completion accepted |
| rsp_id | output | ID_W | Copied request identifier |
| rsp_code | output | CODE_W | 0 success, else fault code |
| rsp_force_irq | output | 1 | Force-interrupt flag |

## Verification
A corrupted phase state shows up at the ports on the very next cycle. It appears as a handshake presented out of order, two handshakes at once, or `req_ready` rising while work is still pending. Each of these is caught in the cycle it occurs. A wrongly latched field or fault code surfaces when the next command, doorbell or completion is compared against the scoreboard. A lost or extra phase leaves the expected queue non-empty, or hits it while empty, once the sequencer goes idle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_PRE, S_XREQ, S_XWAIT, S_POST, S_DB, S_RSP
   } dreq_state_e;

   localparam int unsigned NPHASE   = 5;   // pre, xfer, post, doorbell, response
   localparam int unsigned FAULT_OK    = 0;
   localparam int unsigned FAULT_TYPE  = 1;
   localparam int unsigned FAULT_WIDTH = 2;
   localparam int unsigned FAULT_ALIGN = 3;

   function automatic dreq_state_e phase_state(input int unsigned idx);
      case (idx)
         0: return S_PRE;
         1: return S_XREQ;
         2: return S_POST;
         3: return S_DB;
         default: return S_RSP;
      endcase
   endfunction
endpackage

// File: rtl/dreq_check.sv
module dreq_check #(
   parameter int unsigned CODE_W = 16
) (
   input  logic [1:0]        chk_type,
   input  logic              chk_db_en,
   input  logic [1:0]        chk_db_width,
   input  logic [1:0]        chk_db_off,
   output logic [CODE_W-1:0] chk_code
);
   import dreq_pkg::*;

   logic misaligned;

   always_comb begin
      case (chk_db_width)
         2'd0:    misaligned = (chk_db_off != 2'd0);
         2'd1:    misaligned = chk_db_off[0];
         default: misaligned = 1'b0;
      endcase
   end

   always_comb begin
      if (chk_type == 2'd3)
         chk_code = CODE_W'(FAULT_TYPE);
      else if (chk_db_en && chk_db_width == 2'd3)
         chk_code = CODE_W'(FAULT_WIDTH);
      else if (chk_db_en && misaligned)
         chk_code = CODE_W'(FAULT_ALIGN);
      else
         chk_code = CODE_W'(FAULT_OK);
   end
endmodule

// File: rtl/dreq_db_lanes.sv
module dreq_db_lanes #(
   parameter int unsigned LANES = 4
) (
   input  logic [1:0]         ln_width,
   input  logic [1:0]         ln_off,
   input  logic [8*LANES-1:0] ln_data_in,
   output logic [8*LANES-1:0] ln_data_out,
   output logic [LANES-1:0]   ln_strb
);
   localparam int unsigned DW = 8 * LANES;

   logic [DW-1:0]    masked;
   logic [DW-1:0]    shifted;
   logic [LANES-1:0] base_strb;

   always_comb begin
      case (ln_width)
         2'd0:    begin masked = ln_data_in;                    base_strb = '1;             end
         2'd1:    begin masked = {{(DW-16){1'b0}}, ln_data_in[15:0]}; base_strb = LANES'(2'b11); end
         2'd2:    begin masked = {{(DW-8){1'b0}},  ln_data_in[7:0]};  base_strb = LANES'(1'b1);  end
         default: begin masked = '0;                             base_strb = '0;             end
      endcase
      shifted = masked << (8 * ln_off);
   end

   assign ln_strb = base_strb << ln_off;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign ln_data_out[8*g +: 8] = ln_strb[g] ? shifted[8*g +: 8] : 8'h00;
   end
endmodule

// File: rtl/dreq_phase_sel.sv
module dreq_phase_sel (
   input  logic [dreq_pkg::NPHASE-1:0] ps_need,
   input  logic [2:0]                  ps_from,
   output dreq_pkg::dreq_state_e       ps_next
);
   import dreq_pkg::*;

   always_comb begin
      ps_next = S_IDLE;
      for (int i = NPHASE - 1; i >= 0; i--) begin
         if (ps_need[i] && (3'(i) >= ps_from))
            ps_next = phase_state(i);
      end
   end
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned ID_W   = 16,
   parameter int unsigned LEN_W  = 32,
   parameter int unsigned CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ID_W-1:0]   req_id,
   input  logic              req_force_irq,
   input  logic              req_want_rsp,
   input  logic              req_bulk,
   input  logic [1:0]        req_type,
   input  logic [ADDR_W-1:0] req_src,
   input  logic [ADDR_W-1:0] req_dst,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_pre_en,
   input  logic              req_post_en,
   input  logic              req_db_en,
   input  logic [1:0]        req_db_width,
   input  logic [ADDR_W-1:0] req_db_addr,
   input  logic [31:0]       req_db_data,
   output logic              sem_pre_req,
   input  logic              sem_pre_ok,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic              xfer_bulk,
   output logic [1:0]        xfer_dir,
   output logic [ADDR_W-1:0] xfer_src,
   output logic [ADDR_W-1:0] xfer_dst,
   output logic [LEN_W-1:0]  xfer_len,
   input  logic              xfer_done,
   output logic              sem_post_req,
   input  logic              sem_post_ok,
   output logic              db_valid,
   input  logic              db_ready,
   output logic [ADDR_W-1:0] db_addr,
   output logic [31:0]       db_data,
   output logic [3:0]        db_strb,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ID_W-1:0]   rsp_id,
   output logic [CODE_W-1:0] rsp_code,
   output logic              rsp_force_irq
);
   import dreq_pkg::*;

   localparam int unsigned DB_LANES = 4;

   if (ADDR_W < 2)  begin : g_bad_addr $error("ADDR_W must be at least 2"); end
   if (CODE_W < 2)  begin : g_bad_code $error("CODE_W must hold fault codes"); end
   if (LEN_W > 32 || LEN_W < 1) begin : g_bad_len $error("LEN_W must be 1..32"); end
   if (ID_W < 1)    begin : g_bad_id   $error("ID_W must be positive"); end

   dreq_state_e       st_q, st_d, picked;
   logic [NPHASE-1:0] need_q, need_new, need_sel;
   logic [2:0]        from_idx;
   logic              adv, take;
   logic [CODE_W-1:0] fault_new;

   logic [ID_W-1:0]   id_q;
   logic              force_q, bulk_q;
   logic [1:0]        dir_q, dbw_q;
   logic [ADDR_W-1:0] src_q, dst_q, dba_q;
   logic [LEN_W-1:0]  len_q;
   logic [31:0]       dbd_q;
   logic [CODE_W-1:0] code_q;

   dreq_check #(.CODE_W(CODE_W)) i_check (
      .chk_type     (req_type),
      .chk_db_en    (req_db_en),
      .chk_db_width (req_db_width),
      .chk_db_off   (req_db_addr[1:0]),
      .chk_code     (fault_new)
   );

   always_comb begin
      if (fault_new != '0)
         need_new = {req_want_rsp, 4'b0000};
      else
         need_new = {req_want_rsp, req_db_en, req_post_en, (req_type != 2'd0), req_pre_en};
   end

   assign need_sel = (st_q == S_IDLE) ? need_new : need_q;

   always_comb begin
      from_idx = 3'd0;
      adv      = 1'b0;
      case (st_q)
         S_IDLE:  begin from_idx = 3'd0; adv = req_valid;   end
         S_PRE:   begin from_idx = 3'd1; adv = sem_pre_ok;  end
         S_XWAIT: begin from_idx = 3'd2; adv = xfer_done;   end
         S_POST:  begin from_idx = 3'd3; adv = sem_post_ok; end
         S_DB:    begin from_idx = 3'd4; adv = db_ready;    end
         S_RSP:   begin from_idx = 3'd5; adv = rsp_ready;   end
         default: begin from_idx = 3'd0; adv = 1'b0;        end
      endcase
   end

   dreq_phase_sel i_sel (
      .ps_need (need_sel),
      .ps_from (from_idx),
      .ps_next (picked)
   );

   always_comb begin
      st_d = st_q;
      if (st_q == S_XREQ) begin
         if (xfer_ready) st_d = S_XWAIT;
      end else if (adv) begin
         st_d = picked;
      end
   end

   assign take = (st_q == S_IDLE) && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         need_q <= '0;
      end else begin
         st_q <= st_d;
         if (take) need_q <= need_new;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         id_q    <= req_id;
         force_q <= req_force_irq;
         bulk_q  <= req_bulk;
         dir_q   <= req_type;
         src_q   <= req_src;
         dst_q   <= req_dst;
         len_q   <= req_len;
         dba_q   <= req_db_addr;
         dbw_q   <= req_db_width;
         dbd_q   <= req_db_data;
         code_q  <= fault_new;
      end
   end

   dreq_db_lanes #(.LANES(DB_LANES)) i_lanes (
      .ln_width    (dbw_q),
      .ln_off      (dba_q[1:0]),
      .ln_data_in  (dbd_q),
      .ln_data_out (db_data),
      .ln_strb     (db_strb)
   );

   assign req_ready     = (st_q == S_IDLE);
   assign sem_pre_req   = (st_q == S_PRE);
   assign xfer_valid    = (st_q == S_XREQ);
   assign sem_post_req  = (st_q == S_POST);
   assign db_valid      = (st_q == S_DB);
   assign rsp_valid     = (st_q == S_RSP);
   assign xfer_bulk     = bulk_q;
   assign xfer_dir      = dir_q;
   assign xfer_src      = src_q;
   assign xfer_dst      = dst_q;
   assign xfer_len      = len_q;
   assign db_addr       = dba_q;
   assign rsp_id        = id_q;
   assign rsp_code      = code_q;
   assign rsp_force_irq = force_q;
endmodule

// File: rtl/dma_req_seq_chk.sv
module dma_req_seq_chk #(
   parameter int unsigned ID_W   = 16,
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned LEN_W  = 32,
   parameter int unsigned CODE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              sem_pre_req,
   input logic              sem_pre_ok,
   input logic              xfer_valid,
   input logic              xfer_ready,
   input logic [1:0]        xfer_dir,
   input logic [ADDR_W-1:0] xfer_src,
   input logic [LEN_W-1:0]  xfer_len,
   input logic              sem_post_req,
   input logic              sem_post_ok,
   input logic              db_valid,
   input logic [3:0]        db_strb,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [ID_W-1:0]   rsp_id,
   input logic [CODE_W-1:0] rsp_code
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(sem_pre_req || xfer_valid || sem_post_req || db_valid || rsp_valid));

   p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sem_pre_req, xfer_valid, sem_post_req, db_valid, rsp_valid}));

   p_pre_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sem_pre_req && !sem_pre_ok |=> sem_pre_req);

   p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_src) && $stable(xfer_len));

   p_xfer_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> (xfer_dir == 2'd1 || xfer_dir == 2'd2));

   p_post_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sem_post_req && !sem_post_ok |=> sem_post_req);

   p_db_strb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |-> ($countones(db_strb) == 1 || $countones(db_strb) == 2 || $countones(db_strb) == 4));

   p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id) && $stable(rsp_code));

   p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_code <= CODE_W'(3));
endmodule

bind dma_req_seq dma_req_seq_chk #(
   .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CODE_W(CODE_W)
) i_dma_req_seq_chk (.*);

// File: tb/test_dma_req_seq.sv
module test_dma_req_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 64;

   typedef struct {
      int          kind;   // 1 xfer, 2 doorbell, 3 response
      logic [63:0] v0, v1, v2, v3;
   } ev_t;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_force_irq = 0, req_want_rsp = 0, req_bulk = 0;
   logic [15:0] req_id = 0;
   logic [1:0]  req_type = 0, req_db_width = 0;
   logic [AW-1:0] req_src = 0, req_dst = 0, req_db_addr = 0;
   logic [31:0] req_len = 0, req_db_data = 0;
   logic req_pre_en = 0, req_post_en = 0, req_db_en = 0;
   logic sem_pre_ok = 0, sem_post_ok = 0, xfer_done = 0;
   logic xfer_ready = 1, db_ready = 1, rsp_ready = 1;
   logic req_ready, sem_pre_req, xfer_valid, xfer_bulk, sem_post_req, db_valid, rsp_valid, rsp_force_irq;
   logic [1:0] xfer_dir;
   logic [AW-1:0] xfer_src, xfer_dst, db_addr;
   logic [31:0] xfer_len, db_data;
   logic [3:0] db_strb;
   logic [15:0] rsp_id, rsp_code;

   int n_chk = 0, n_bad = 0;
   int pre_cnt = 0, post_cnt = 0, rsp_cnt = 0;
   logic done_pend = 0;
   ev_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_req_seq i_dma_req_seq (.*);

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic compare(input ev_t a, input string rq);
      ev_t e;
      if (q.size() == 0) begin
         chk(0, rq, "unexpected event kind", 64'(a.kind), 64'd0);
         return;
      end
      e = q.pop_front();
      chk(e.kind == a.kind, {"R2 ", rq}, "event order", 64'(a.kind), 64'(e.kind));
      if (e.kind == a.kind) begin
         chk(e.v0 == a.v0, rq, "field0", a.v0, e.v0);
         chk(e.v1 == a.v1, rq, "field1", a.v1, e.v1);
         chk(e.v2 == a.v2, rq, "field2", a.v2, e.v2);
         chk(e.v3 == a.v3, rq, "field3", a.v3, e.v3);
      end
   endtask

   // responders and monitor
   always @(negedge clk) begin
      ev_t a;
      if (rst_n) begin
         xfer_done = done_pend;
         done_pend = xfer_valid;
         sem_pre_ok = sem_pre_req && (pre_cnt == 0);
         if (sem_pre_req && pre_cnt != 0) begin
            pre_cnt--;
            chk(!xfer_valid && !db_valid && !rsp_valid, "R3", "activity while pre-gate closed", 64'(xfer_valid), 64'd0);
         end
         sem_post_ok = sem_post_req && (post_cnt == 0);
         if (sem_post_req && post_cnt != 0) begin
            post_cnt--;
            chk(!db_valid && !rsp_valid, "R5", "activity while post-gate closed", 64'(db_valid), 64'd0);
         end
         rsp_ready = !(rsp_valid && rsp_cnt != 0);
         if (rsp_valid && rsp_cnt != 0) rsp_cnt--;
         if (xfer_valid) begin
            a.kind = 1; a.v0 = {61'd0, xfer_bulk, xfer_dir}; a.v1 = xfer_src; a.v2 = xfer_dst; a.v3 = 64'(xfer_len);
            compare(a, "R4");
         end
         if (db_valid) begin
            a.kind = 2; a.v0 = db_addr; a.v1 = 64'(db_data); a.v2 = 64'(db_strb); a.v3 = 0;
            compare(a, "R6");
         end
         if (rsp_valid && rsp_ready) begin
            a.kind = 3; a.v0 = 64'(rsp_id); a.v1 = 64'(rsp_code); a.v2 = 64'(rsp_force_irq); a.v3 = 0;
            compare(a, "R7");
         end
      end
   end

   task automatic push(input int k, input logic [63:0] a0, a1, a2, a3);
      ev_t e;
      e.kind = k; e.v0 = a0; e.v1 = a1; e.v2 = a2; e.v3 = a3;
      q.push_back(e);
   endtask

   task automatic run(input logic [15:0] id, input logic [1:0] typ, input logic bulk,
                      input logic [AW-1:0] src, dst, input logic [31:0] len,
                      input logic pre, input int pre_st, input logic post, input int post_st,
                      input logic dben, input logic [1:0] dbw, input logic [AW-1:0] dba,
                      input logic [31:0] dbd, input logic want, input logic frc, input int rsp_st,
                      input string rq);
      int code;
      logic [31:0] m, d;
      logic [3:0] s;
      code = 0;
      if (typ == 2'd3) code = 1;
      else if (dben && dbw == 2'd3) code = 2;
      else if (dben && ((dbw == 2'd0 && dba[1:0] != 0) || (dbw == 2'd1 && dba[0]))) code = 3;
      if (code == 0) begin
         if (typ != 0) push(1, {61'd0, bulk, typ}, src, dst, 64'(len));
         if (dben) begin
            m = (dbw == 0) ? 32'hFFFF_FFFF : (dbw == 1) ? 32'h0000_FFFF : 32'h0000_00FF;
            s = (dbw == 0) ? 4'hF : (dbw == 1) ? 4'h3 : 4'h1;
            d = (dbd & m) << (8 * dba[1:0]);
            s = s << dba[1:0];
            push(2, dba, 64'(d), 64'(s), 0);
         end
      end
      if (want) push(3, 64'(id), 64'(code), 64'(frc), 0);
      pre_cnt = pre_st; post_cnt = post_st; rsp_cnt = rsp_st;
      while (!req_ready) @(negedge clk);
      req_id = id; req_type = typ; req_bulk = bulk; req_src = src; req_dst = dst; req_len = len;
      req_pre_en = pre; req_post_en = post; req_db_en = dben; req_db_width = dbw;
      req_db_addr = dba; req_db_data = dbd; req_want_rsp = want; req_force_irq = frc;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      req_id = 16'hDEAD; req_src = '1; req_type = 2'd3;
      if (!(code != 0 && !want))
         chk(req_ready == 0, "R1", "ready while busy", 64'(req_ready), 64'd0);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      chk(q.size() == 0, rq, "missing events at idle", 64'(q.size()), 64'd0);
      q.delete();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready == 1, "R1", "ready after reset", 64'(req_ready), 64'd1);
      chk({sem_pre_req, xfer_valid, sem_post_req, db_valid, rsp_valid} == 0, "R1", "outputs after reset",
          64'({sem_pre_req, xfer_valid, sem_post_req, db_valid, rsp_valid}), 64'd0);
      // full sequence with gate stalls (R2 R3 R5)
      run(16'h0101, 2'd1, 1'b1, 64'h1000, 64'h2000, 32'hFFFF_FFFF, 1, 3, 1, 2,
          1, 2'd0, 64'h8000, 32'hCAFE_BABE, 1, 1, 0, "R2");
      // from device, linked list, 16-bit doorbell in upper half (R4 R6)
      run(16'h0202, 2'd2, 1'b0, 64'hAB00, 64'hCD00, 32'd64, 0, 0, 0, 0,
          1, 2'd1, 64'h9002, 32'h1234_5678, 1, 0, 0, "R6");
      // no transfer, byte doorbell on lane 3
      run(16'h0303, 2'd0, 1'b1, 0, 0, 0, 1, 0, 0, 0,
          1, 2'd2, 64'h9003, 32'hAABB_CCDD, 1, 0, 0, "R4");
      // faults (R8)
      run(16'h0404, 2'd3, 1'b1, 1, 2, 3, 1, 0, 1, 0, 0, 2'd0, 0, 0, 1, 0, 0, "R8");
      run(16'h0505, 2'd1, 1'b1, 1, 2, 3, 1, 0, 1, 0, 1, 2'd3, 64'h10, 0, 1, 1, 0, "R8");
      run(16'h0606, 2'd1, 1'b1, 1, 2, 3, 0, 0, 0, 0, 1, 2'd0, 64'h11, 0, 1, 0, 0, "R8");
      run(16'h0707, 2'd2, 1'b0, 1, 2, 3, 0, 0, 0, 0, 1, 2'd1, 64'h13, 0, 1, 0, 0, "R8");
      run(16'h0808, 2'd3, 1'b0, 1, 2, 3, 0, 0, 0, 0, 1, 2'd3, 64'h13, 0, 1, 0, 0, "R8");
      // no completion, even on fault (R9)
      run(16'h0909, 2'd3, 1'b0, 1, 2, 3, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, 1, 0, "R9");
      run(16'h0A0A, 2'd1, 1'b0, 64'h55, 64'h66, 32'd7, 0, 0, 1, 1, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
      // disabled doorbell with reserved width and odd address raises no fault (R9)
      run(16'h0B0B, 2'd2, 1'b1, 64'h77, 64'h88, 32'd9, 0, 0, 0, 0, 0, 2'd3, 64'h7, 0, 1, 0, 0, "R9");
      // completion backpressure (R7)
      run(16'h0C0C, 2'd0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 1, 1, 3, "R7");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule